// File: doc/BRIEF.md
# Translation Buffer with Hardware Page-Table Walker

This block turns 32-bit virtual addresses into 30-bit physical addresses for 4 KiB pages. It keeps a small, fully associative set of recent translations. A hit is answered in the cycle after the request is taken. On a miss, a built-in walker reads the page-table entry from memory, installs it, and runs the lookup again. The page table is a single flat array. Its base address is a register input, and the virtual page number indexes it.

Each cached translation carries a reference bit and a dirty bit. An access sets the reference bit. A write also sets the dirty bit. A per-entry "modified" flag records whether either bit has changed since the entry was fetched. When a modified entry is evicted, the walker writes its entry back to the table before it reads the new one.

Free slots are filled first. When none is free, a free-running LFSR picks the victim. An entry that is absent, or that sets a reserved bit, raises a page fault and nothing is installed. A flush input drops every cached translation in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: The virtual page number is `vaddr[31:12]` and the page offset is `vaddr[11:0]`. A successful response carries `paddr = {ppn, vaddr[11:0]}`, where ppn comes from bits 17:0 of the page-table entry.
- R2: A lookup that hits raises `rsp_valid_o` in the cycle after the request is accepted. It makes no memory access and sets `rsp_fault_o` low.
- R3: On a miss, one read is issued at address `pt_base_i + 4*vpn`. The entry is installed and the lookup is retried, and the response follows. `mem_valid_o`, `mem_write_o` and `mem_addr_o` stay stable until `mem_ready_i` completes the beat.
- R4: A fetched entry faults when its present bit (bit 31) is 0 or any reserved bit (28:18) is 1. A faulting entry gives a response with `rsp_fault_o=1` and `rsp_paddr_o=0`, and installs nothing, so the same page misses again.
- R5: While any slot is invalid, a miss fills an invalid slot and makes no write-back.
- R6: When a modified entry is evicted, one write precedes the read. It goes to `pt_base_i + 4*victim_vpn` with data `{1'b1, ref, dirty, 11'b0, ppn}`, where bit 30 is ref and bit 29 is dirty.
- R7: A write access sets the entry's dirty bit. Installing sets the reference bit, and the dirty bit becomes the fetched dirty bit (bit 29) ORed with the write flag.
- R8: A one-cycle pulse on `flush_i` invalidates every entry, so later accesses miss.
- R9: `req_ready_o` is high when idle, including out of reset. It is low from the cycle after a miss is accepted until the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all cached translations |
| pt_base_i | input | 30 | Physical base address of the page table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write access |
| rsp_valid_o | output | 1 | Response valid for one cycle |
| rsp_fault_o | output | 1 | Page fault for this response |
| rsp_paddr_o | output | 30 | Translated physical address, zero on fault |
| mem_valid_o | output | 1 | Memory beat requested |
| mem_ready_i | input | 1 | Memory beat completes this cycle |
| mem_write_o | output | 1 | Beat is a write-back |
| mem_addr_o | output | 30 | Page-table entry address |
| mem_wdata_o | output | 32 | Entry written back |
| mem_rdata_i | input | 32 | Entry read, valid with `mem_ready_i` |

## Verification
The bench builds the block with four entries instead of sixteen. With only four slots, capacity eviction, LFSR victim choice and write-back ordering occur after a handful of accesses. A sweep over eight pages then exercises them dozens of times.

The bench's memory model clears the reference bit on every write-back, so every installed entry is modified. As a result, each eviction shows up as a write whose address identifies the victim. That lets the bench track residency exactly even though the victim is chosen at random.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PTE_W       = 32;
  localparam int PTE_PRESENT = 31;
  localparam int PTE_REF     = 30;
  localparam int PTE_DIRTY   = 29;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FETCH,
    ST_RETRY
  } walk_state_e;
endpackage

// File: rtl/xlat_lfsr.sv
module xlat_lfsr #(
  parameter int W     = 8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] pick_o
);
  logic [W-1:0] q, q_d;
  logic         fb;

  generate
    if (W == 16) begin : g_w16
      assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];
    end else if (W == 8) begin : g_w8
      assign fb = q[7] ^ q[5] ^ q[4] ^ q[3];
    end else begin : g_wx
      assign fb = q[W-1] ^ q[W-2];
    end
  endgenerate

  always_comb q_d = {q[W-2:0], fb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= W'(1);
    else        q <= q_d;
  end

  assign pick_o = q[OUT_W-1:0];
endmodule

// File: rtl/xlat_entries.sv
module xlat_entries #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output logic             free_any_o,
  output logic [IDX_W-1:0] free_idx_o,
  input  logic [IDX_W-1:0] vic_idx_i,
  output logic             vic_valid_o,
  output logic [VPN_W-1:0] vic_vpn_o,
  output logic [PPN_W-1:0] vic_ppn_o,
  output logic             vic_ref_o,
  output logic             vic_dirty_o,
  output logic             vic_mod_o,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             touch_write_i,
  input  logic             evict_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_dirty_i,
  input  logic             fill_mod_i
);
  logic [ENTRIES-1:0] val_q, ref_q, dirty_q, mod_q;
  logic [ENTRIES-1:0] val_d, ref_d, dirty_d, mod_d;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = val_q[e] && (vpn_q[e] == lk_vpn_i);
    end
  endgenerate

  always_comb begin
    lk_idx_o   = '0;
    lk_ppn_o   = '0;
    free_idx_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_vec[e]) begin
        lk_idx_o = lk_idx_o | IDX_W'(e);
        lk_ppn_o = lk_ppn_o | ppn_q[e];
      end
    end
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!val_q[e]) free_idx_o = IDX_W'(e);
    end
  end

  assign lk_hit_o    = |hit_vec;
  assign free_any_o  = ~&val_q;
  assign vic_valid_o = val_q[vic_idx_i];
  assign vic_vpn_o   = vpn_q[vic_idx_i];
  assign vic_ppn_o   = ppn_q[vic_idx_i];
  assign vic_ref_o   = ref_q[vic_idx_i];
  assign vic_dirty_o = dirty_q[vic_idx_i];
  assign vic_mod_o   = mod_q[vic_idx_i];

  always_comb begin
    val_d   = val_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    mod_d   = mod_q;
    if (touch_i) begin
      if (!ref_q[touch_idx_i]) mod_d[touch_idx_i] = 1'b1;
      ref_d[touch_idx_i] = 1'b1;
      if (touch_write_i && !dirty_q[touch_idx_i]) begin
        dirty_d[touch_idx_i] = 1'b1;
        mod_d[touch_idx_i]   = 1'b1;
      end
    end
    if (evict_i) val_d[vic_idx_i] = 1'b0;
    if (fill_i) begin
      val_d[fill_idx_i]   = 1'b1;
      ref_d[fill_idx_i]   = 1'b1;
      dirty_d[fill_idx_i] = fill_dirty_i;
      mod_d[fill_idx_i]   = fill_mod_i;
    end
    if (flush_i) val_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      mod_q   <= '0;
    end else begin
      val_q   <= val_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
      mod_q   <= mod_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_i) begin
      vpn_q[fill_idx_i] <= fill_vpn_i;
      ppn_q[fill_idx_i] <= fill_ppn_i;
    end
  end

  // R8: a flush leaves no valid slot behind
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (val_q == '0));
  // R3: installs never create two matches for one page
  a_r3_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R7: a write hit leaves the entry dirty
  a_r7_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_i && touch_write_i) |=> dirty_q[$past(touch_idx_i)]);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFS_W   = 12,
  parameter int LFSR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [PA_W-1:0]  pt_base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic             mem_write_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PAD_W = PA_W - VPN_W - 2;

  walk_state_e      state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [IDX_W-1:0] vic_q;
  logic             rsp_valid_d, rsp_fault_d;
  logic [PA_W-1:0]  rsp_paddr_d;

  logic             accept, look_go, lk_write, lk_hit;
  logic [VA_W-1:0]  lk_va;
  logic [IDX_W-1:0] lk_idx, free_idx, vic_sel, vic_rd_idx, rnd_idx;
  logic [PPN_W-1:0] lk_ppn, vic_ppn;
  logic [VPN_W-1:0] vic_vpn, walk_vpn;
  logic             free_any, vic_valid, vic_ref, vic_dirty, vic_mod;
  logic             pte_ok, fill, evict;

  assign accept     = (state_q == ST_IDLE) && req_valid_i;
  assign look_go    = accept || (state_q == ST_RETRY);
  assign lk_va      = (state_q == ST_RETRY) ? va_q : req_vaddr_i;
  assign lk_write   = (state_q == ST_RETRY) ? wr_q : req_write_i;
  assign vic_sel    = free_any ? free_idx : rnd_idx;
  assign vic_rd_idx = (state_q == ST_WBACK) ? vic_q : vic_sel;
  assign evict      = look_go && !lk_hit;
  assign walk_vpn   = (state_q == ST_WBACK) ? vic_vpn : va_q[VA_W-1:OFS_W];

  assign pte_ok = mem_rdata_i[PTE_PRESENT] && (mem_rdata_i[PTE_DIRTY-1:PPN_W] == '0);
  assign fill   = (state_q == ST_FETCH) && mem_ready_i && pte_ok;

  xlat_lfsr #(.W(LFSR_W), .OUT_W(IDX_W)) i_rnd (
    .clk(clk), .rst_n(rst_n), .pick_o(rnd_idx));

  xlat_entries #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_ent (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_vpn_i(lk_va[VA_W-1:OFS_W]), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx), .lk_ppn_o(lk_ppn),
    .free_any_o(free_any), .free_idx_o(free_idx),
    .vic_idx_i(vic_rd_idx), .vic_valid_o(vic_valid), .vic_vpn_o(vic_vpn), .vic_ppn_o(vic_ppn),
    .vic_ref_o(vic_ref), .vic_dirty_o(vic_dirty), .vic_mod_o(vic_mod),
    .touch_i(look_go && lk_hit), .touch_idx_i(lk_idx), .touch_write_i(lk_write),
    .evict_i(evict),
    .fill_i(fill), .fill_idx_i(vic_q), .fill_vpn_i(va_q[VA_W-1:OFS_W]),
    .fill_ppn_i(mem_rdata_i[PPN_W-1:0]),
    .fill_dirty_i(mem_rdata_i[PTE_DIRTY] | wr_q),
    .fill_mod_i(!mem_rdata_i[PTE_REF] | (wr_q & !mem_rdata_i[PTE_DIRTY])));

  always_comb begin
    mem_valid_o = (state_q == ST_WBACK) || (state_q == ST_FETCH);
    mem_write_o = (state_q == ST_WBACK);
    mem_addr_o  = pt_base_i + {{PAD_W{1'b0}}, walk_vpn, 2'b00};
    mem_wdata_o = '0;
    mem_wdata_o[PTE_PRESENT] = 1'b1;
    mem_wdata_o[PTE_REF]     = vic_ref;
    mem_wdata_o[PTE_DIRTY]   = vic_dirty;
    mem_wdata_o[PPN_W-1:0]   = vic_ppn;
  end

  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_fault_d = 1'b0;
    rsp_paddr_d = '0;
    unique case (state_q)
      ST_IDLE, ST_RETRY: begin
        if (look_go) begin
          if (lk_hit) begin
            rsp_valid_d = 1'b1;
            rsp_paddr_d = {lk_ppn, lk_va[OFS_W-1:0]};
            state_d     = ST_IDLE;
          end else begin
            state_d = (vic_valid && vic_mod) ? ST_WBACK : ST_FETCH;
          end
        end
      end
      ST_WBACK: if (mem_ready_i) state_d = ST_FETCH;
      ST_FETCH: begin
        if (mem_ready_i) begin
          if (pte_ok) begin
            state_d = ST_RETRY;
          end else begin
            rsp_valid_d = 1'b1;
            rsp_fault_d = 1'b1;
            state_d     = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= rsp_valid_d;
      rsp_fault_o <= rsp_fault_d;
      rsp_paddr_o <= rsp_paddr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      va_q <= req_vaddr_i;
      wr_q <= req_write_i;
    end
    if (evict) vic_q <= vic_sel;
  end

  assign req_ready_o = (state_q == ST_IDLE);

  // R9: no request is taken while the walker owns the memory port
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> !req_ready_o);
  // R2: a hit answers on the next cycle without a fault
  a_r2_hit_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (look_go && lk_hit) |=> (rsp_valid_o && !rsp_fault_o));
  // R4: a faulting response carries no address
  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0));
  // R6: a completed write-back is followed at once by the read
  a_r6_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_write_o && mem_ready_i) |=> (mem_valid_o && !mem_write_o));
  // R3: a pending memory beat holds its command
  a_r3_beat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_write_o)));
endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  localparam int ENTRIES = 4;
  localparam logic [29:0] BASE = 30'h0010_0000;

  logic        clk, rst_n, flush_i;
  logic        req_valid_i, req_ready_o, req_write_i;
  logic [31:0] req_vaddr_i;
  logic        rsp_valid_o, rsp_fault_o;
  logic [29:0] rsp_paddr_o;
  logic        mem_valid_o, mem_ready_i, mem_write_o;
  logic [29:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  xlat_cache #(.ENTRIES(ENTRIES), .LFSR_W(8)) i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .pt_base_i(BASE),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .req_write_i(req_write_i),
    .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_paddr_o(rsp_paddr_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_write_o(mem_write_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [29:0] pa;
    logic        fault;
  } exp_t;

  exp_t            sb[$];
  logic [31:0]     pt[int unsigned];
  int unsigned     res_q[$];
  bit              res_dirty[int unsigned];
  int              n_checks = 0, n_err = 0, n_rd = 0, n_wr = 0;
  logic [29:0]     last_rd;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_of(int unsigned vpn);
    if (pt.exists(vpn)) return pt[vpn];
    return 32'h0;
  endfunction

  function automatic int find_res(int unsigned vpn);
    foreach (res_q[k]) if (res_q[k] == vpn) return k;
    return -1;
  endfunction

  // memory model: one-cycle wait, then complete the beat
  initial begin
    mem_ready_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) mem_ready_i = 1'b0;
      else if (mem_valid_o && !mem_ready_i) begin
        int unsigned vpn;
        vpn = int'((mem_addr_o - BASE) >> 2);
        mem_ready_i = 1'b1;
        if (mem_write_o) begin
          int k;
          n_wr++;
          k = find_res(vpn);
          check(k >= 0, "R6", "write-back of a resident page", vpn, 0);
          if (k >= 0) begin
            check(mem_wdata_o == {1'b1, 1'b1, res_dirty[vpn], 11'b0, pt[vpn][17:0]},
                  "R6", "write-back data", mem_wdata_o,
                  {1'b1, 1'b1, res_dirty[vpn], 11'b0, pt[vpn][17:0]});
            res_q.delete(k);
          end
          pt[vpn] = mem_wdata_o & ~32'h4000_0000;
        end else begin
          n_rd++;
          last_rd = mem_addr_o;
          mem_rdata_i = pte_of(vpn);
        end
      end else mem_ready_i = 1'b0;
    end
  end

  // monitor: every response pops one expected item
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid_o) begin
        if (sb.size() == 0) check(1'b0, "R1", "unexpected response", rsp_paddr_o, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_fault_o == e.fault, "R4", "fault flag", rsp_fault_o, e.fault);
          check(rsp_paddr_o == e.pa, "R1", "physical address", rsp_paddr_o, e.pa);
        end
      end
    end
  end

  task automatic access(int unsigned vpn, int unsigned ofs, bit wr);
    logic [31:0] pte;
    bit hit, full, good;
    int rd0, wr0, g;
    exp_t e;
    pte  = pte_of(vpn);
    hit  = find_res(vpn) >= 0;
    full = res_q.size() == ENTRIES;
    good = pte[31] && (pte[28:18] == 11'h0);
    rd0  = n_rd;
    wr0  = n_wr;
    e.pa    = good ? {pte[17:0], ofs[11:0]} : 30'h0;
    e.fault = !good;
    sb.push_back(e);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_vaddr_i = {vpn[19:0], ofs[11:0]};
    req_write_i = wr;
    check(req_ready_o, "R9", "ready while idle", req_ready_o, 1);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (hit) begin
      check(rsp_valid_o, "R2", "hit answered next cycle", rsp_valid_o, 1);
      check(n_rd == rd0 && n_wr == wr0, "R2", "no memory traffic on hit", n_rd - rd0, 0);
      if (wr) res_dirty[vpn] = 1'b1;
    end else begin
      check(!req_ready_o, "R9", "ready low during walk", req_ready_o, 0);
      g = 0;
      while (!rsp_valid_o && g < 1000) begin
        @(negedge clk);
        g++;
      end
      check(n_rd == rd0 + 1, "R3", "one table read per miss", n_rd - rd0, 1);
      check(last_rd == BASE + 30'(vpn * 4), "R3", "read address", last_rd, BASE + 30'(vpn * 4));
      if (full) check(n_wr == wr0 + 1, "R6", "write-back before refill", n_wr - wr0, 1);
      else      check(n_wr == wr0, "R5", "free slot used, no write-back", n_wr - wr0, 0);
      if (good) begin
        res_q.push_back(vpn);
        res_dirty[vpn] = pte[29] | wr;
      end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush_i = 1'b0;
    req_valid_i = 1'b0; req_write_i = 1'b0; req_vaddr_i = '0;
    for (int v = 1; v <= 8; v++) pt[v] = {1'b1, 1'b0, (v == 3), 11'b0, 18'(18'h100 + v * 7)};
    pt[32'hFFFFF] = {1'b1, 2'b00, 11'b0, 18'h3FFFF};
    pt[32'h21]    = 32'h8004_0005;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready_o, "R9", "ready after reset", req_ready_o, 1);
    check(!rsp_valid_o, "R2", "no response after reset", rsp_valid_o, 0);
    check(!mem_valid_o, "R3", "memory idle after reset", mem_valid_o, 0);

    access(1, 12'h123, 0);
    access(1, 12'hABC, 0);
    access(2, 12'h004, 1);
    access(3, 12'hFFF, 0);
    access(4, 12'h000, 0);
    access(1, 12'h555, 1);   // R7: dirty via write hit
    access(5, 12'h010, 0);   // R6: first eviction
    for (int i = 0; i < 40; i++) access(1 + (i * 5) % 8, (i * 97) & 12'hFFF, (i % 3) == 0);
    access(32'h20, 12'h001, 0);  // R4: absent page
    access(32'h20, 12'h002, 0);  // R4: still not installed
    access(32'h21, 12'h003, 0);  // R4: reserved bit set
    access(32'hFFFFF, 12'hFFF, 1);  // R1: top of both spaces
    access(32'hFFFFF, 12'h001, 0);
    @(negedge clk); flush_i = 1'b1;   // R8
    @(negedge clk); flush_i = 1'b0;
    res_q.delete();
    access(32'hFFFFF, 12'h002, 0);
    access(6, 12'h0AA, 0);
    access(6, 12'h0BB, 1);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R1", "all responses seen", sb.size(), 0);
    summary();
    $finish;
  end
endmodule